// File: doc/BRIEF.md
# Receiver-Detect Polling Controller

This controller sits beside the output stages of a multi-lane link redriver. It decides, for each lane, when a valid far-end termination has been found. It issues probe requests to an analog comparator and reads the comparator's per-lane verdict. It drives a per-lane termination-select output: high impedance while detection is pending, and matched 50-ohm termination once detection completes.

A strap input selects the policy, and is expected to change only while `rst_ni` is low:

| Strap value | Policy |
|---|---|
| 0 | Detection off |
| 1 | Probe until three consecutive good verdicts |
| 2 | Probe until two consecutive good verdicts |
| 3 | Reserved |
| 4 | Slow periodic probing until the first good verdict |

A microsecond tick sets the probe spacing. Two power-down inputs each hold one half of the lanes in reset. In the periodic mode, a restart requires a qualified long pulse on both inputs.

Top module: `rxdet_poll_ctrl`

## Requirements
- R1: For strap values 0, 3, 5, 6 and 7, every `term_o` bit is 1 (50 ohm), `done_o` is all zero and no `probe_o` pulse is issued.
- R2: With strap 1, a lane sets `done_o` after three consecutive probes whose result was 1, and issues no further probes after that.
- R3: With strap 2, a lane sets `done_o` after two consecutive probes whose result was 1.
- R4: In strap modes 1 and 2, a probe whose result is 0 clears that lane's run of good results, so counting starts over.
- R5: In detecting modes (1, 2, 4), `term_o` of a lane is 0 (high impedance) until its `done_o` is set, and is 1 once it is set. `done_o` only rises on the cycle after a probe.
- R6: With strap 4, a lane probes every `POLL_US` ticks until its first result of 1, then stops probing and sets `done_o`.
- R7: In strap modes 1 and 2, probes of a pending lane are spaced `RETRY_US` ticks apart.
- R8: `probe_o` pulses are one clock cycle wide. `det_result_i` is sampled at the clock edge that ends the pulse.
- R9: `pd_i[0]` holds lanes 0 to NUM_LANES/2-1 and `pd_i[1]` holds the upper half. A held lane has `term_o` 0 and issues no probes, while the other half is unaffected. In modes 1 and 2, a held lane's `done_o` is cleared and detection reruns after release.
- R10: In strap mode 4, detection state is cleared only when both `pd_i` bits have been high for at least `PD_HOLD_US` ticks and then both are low. A shorter pulse forces `term_o` to 0 only while it lasts.
- R11: Asserting `rst_ni` clears all detection state, and detection starts again after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| us_tick_i | input | 1 | One-cycle pulse every microsecond |
| mode_i | input | 3 | Detection policy strap |
| pd_i | input | 2 | Power-down for lower (bit 0) and upper (bit 1) lane halves |
| det_result_i | input | NUM_LANES | Comparator verdict per lane, 1 = termination seen |
| probe_o | output | NUM_LANES | Probe request pulse per lane |
| done_o | output | NUM_LANES | Detection complete per lane |
| term_o | output | NUM_LANES | Termination select, 1 = 50 ohm, 0 = high impedance |

## Verification
The hardest state to reach is the periodic-mode restart. It needs both power-down inputs high for the full hold window, and then a probe sequence that starts over from a lane that had already finished. The stimulus first applies a pulse well short of the window and shows that no new probe follows. It then applies a pulse beyond the window and counts exactly one fresh probe per lane. In the count modes, a per-lane result script keyed to the probe index inserts an isolated bad verdict. The final probe count then shows whether the run of good verdicts was restarted.

// File: rtl/rxdet_pkg.sv
package rxdet_pkg;
  localparam int CNT_W = 2;

  typedef enum logic [2:0] {
    MODE_OFF      = 3'd0,
    MODE_CNT3     = 3'd1,
    MODE_CNT2     = 3'd2,
    MODE_RSVD     = 3'd3,
    MODE_PERIODIC = 3'd4
  } mode_e;

  typedef struct packed {
    logic             active;
    logic             periodic;
    logic [CNT_W-1:0] need;
  } mode_cfg_t;

  function automatic mode_cfg_t decode_mode(logic [2:0] m);
    mode_cfg_t c;
    c = '{active: 1'b0, periodic: 1'b0, need: '0};
    case (m)
      MODE_CNT3:     c = '{active: 1'b1, periodic: 1'b0, need: CNT_W'(3)};
      MODE_CNT2:     c = '{active: 1'b1, periodic: 1'b0, need: CNT_W'(2)};
      MODE_PERIODIC: c = '{active: 1'b1, periodic: 1'b1, need: CNT_W'(1)};
      default:       c = '{active: 1'b0, periodic: 1'b0, need: '0};
    endcase
    return c;
  endfunction
endpackage

// File: rtl/rxdet_poll_timer.sv
module rxdet_poll_timer #(
  parameter int POLL_US  = 150,
  parameter int RETRY_US = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic en_i,
  input  logic periodic_i,
  output logic poll_o
);
  localparam int MAX_US = (POLL_US > RETRY_US) ? POLL_US : RETRY_US;
  localparam int W      = $clog2(MAX_US + 1);

  logic [W-1:0] cnt_q, lim;

  assign lim    = periodic_i ? W'(POLL_US - 1) : W'(RETRY_US - 1);
  assign poll_o = en_i && tick_i && (cnt_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!en_i)  cnt_q <= '0;
    else if (tick_i) cnt_q <= (cnt_q >= lim) ? '0 : cnt_q + W'(1);
  end
endmodule

// File: rtl/rxdet_pd_qual.sv
module rxdet_pd_qual #(
  parameter int HOLD_US = 200
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic [1:0] pd_i,
  output logic       restart_o
);
  localparam int W = $clog2(HOLD_US + 1);

  logic [W-1:0] hold_q;
  logic         armed_q, restart_q;

  assign restart_o = restart_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q    <= '0;
      armed_q   <= 1'b0;
      restart_q <= 1'b0;
    end else begin
      restart_q <= 1'b0;
      if (pd_i == 2'b11) begin
        if (tick_i && hold_q < W'(HOLD_US)) hold_q <= hold_q + W'(1);
        if (hold_q >= W'(HOLD_US))          armed_q <= 1'b1;
      end else begin
        hold_q <= '0;
      end
      // restart fires once both halves are released after a qualified hold
      if (armed_q && pd_i == 2'b00) begin
        armed_q   <= 1'b0;
        restart_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/rxdet_lane.sv
module rxdet_lane
  import rxdet_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  mode_cfg_t cfg_i,
  input  logic      pd_i,
  input  logic      poll_i,
  input  logic      restart_i,
  input  logic      det_i,
  output logic      probe_o,
  output logic      done_o,
  output logic      term_o
);
  logic             probe_q, done_q;
  logic [CNT_W-1:0] run_q;
  logic [CNT_W:0]   run_nxt;

  assign run_nxt = {1'b0, run_q} + (CNT_W+1)'(1);
  assign probe_o = probe_q;
  assign done_o  = done_q;
  assign term_o  = !cfg_i.active || (!pd_i && done_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      probe_q <= 1'b0;
      done_q  <= 1'b0;
      run_q   <= '0;
    end else if (!cfg_i.active) begin
      probe_q <= 1'b0;
      done_q  <= 1'b0;
      run_q   <= '0;
    end else if (pd_i) begin
      probe_q <= 1'b0;
      run_q   <= '0;
      if (!cfg_i.periodic) done_q <= 1'b0;
    end else if (restart_i && cfg_i.periodic) begin
      probe_q <= 1'b0;
      done_q  <= 1'b0;
      run_q   <= '0;
    end else begin
      probe_q <= poll_i && !done_q;
      if (probe_q) begin
        if (!det_i) begin
          run_q <= '0;
        end else if (run_nxt >= {1'b0, cfg_i.need}) begin
          done_q <= 1'b1;
          run_q  <= '0;
        end else begin
          run_q <= run_nxt[CNT_W-1:0];
        end
      end
    end
  end
endmodule

// File: rtl/rxdet_poll_ctrl.sv
module rxdet_poll_ctrl
  import rxdet_pkg::*;
#(
  parameter int NUM_LANES  = 8,
  parameter int POLL_US    = 150,
  parameter int RETRY_US   = 8,
  parameter int PD_HOLD_US = 200
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 us_tick_i,
  input  logic [2:0]           mode_i,
  input  logic [1:0]           pd_i,
  input  logic [NUM_LANES-1:0] det_result_i,
  output logic [NUM_LANES-1:0] probe_o,
  output logic [NUM_LANES-1:0] done_o,
  output logic [NUM_LANES-1:0] term_o
);
  localparam int HALF = NUM_LANES / 2;

  mode_cfg_t cfg;
  logic      poll, restart;

  assign cfg = decode_mode(mode_i);

  rxdet_poll_timer #(.POLL_US(POLL_US), .RETRY_US(RETRY_US)) timer_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(us_tick_i),
    .en_i(cfg.active), .periodic_i(cfg.periodic), .poll_o(poll)
  );

  rxdet_pd_qual #(.HOLD_US(PD_HOLD_US)) qual_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(us_tick_i),
    .pd_i(pd_i), .restart_o(restart)
  );

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    rxdet_lane lane_i (
      .clk_i(clk_i), .rst_ni(rst_ni), .cfg_i(cfg),
      .pd_i(pd_i[(l >= HALF) ? 1 : 0]),
      .poll_i(poll), .restart_i(restart), .det_i(det_result_i[l]),
      .probe_o(probe_o[l]), .done_o(done_o[l]), .term_o(term_o[l])
    );
  end
endmodule

// File: rtl/rxdet_poll_ctrl_chk.sv
module rxdet_poll_ctrl_chk #(
  parameter int NUM_LANES = 8
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [2:0]           mode_i,
  input logic [1:0]           pd_i,
  input logic [NUM_LANES-1:0] probe_o,
  input logic [NUM_LANES-1:0] done_o,
  input logic [NUM_LANES-1:0] term_o
);
  localparam int HALF = NUM_LANES / 2;

  logic inact;
  assign inact = !(mode_i == 3'd1 || mode_i == 3'd2 || mode_i == 3'd4);

  AST_OFF_TERM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inact |-> (&term_o && done_o == '0)); // R1
  AST_OFF_NO_PROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inact |=> (probe_o == '0)); // R1

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_chk
    AST_PD_HIZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!inact && pd_i[(l >= HALF) ? 1 : 0]) |-> !term_o[l]); // R9
    AST_PROBE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      probe_o[l] |=> !probe_o[l]); // R8
    AST_DONE_AFTER_PROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(done_o[l]) |-> $past(probe_o[l])); // R5
    AST_NO_PROBE_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      probe_o[l] |-> !$past(done_o[l])); // R2
  end
endmodule

bind rxdet_poll_ctrl rxdet_poll_ctrl_chk #(.NUM_LANES(NUM_LANES)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i), .pd_i(pd_i),
  .probe_o(probe_o), .done_o(done_o), .term_o(term_o)
);

// File: tb/rxdet_poll_ctrl_tb_top.sv
module rxdet_poll_ctrl_tb_top;
  localparam int N = 8;
  localparam int TICK_DIV = 4;
  localparam int POLL = 150, RETRY = 8, HOLD = 200;

  logic clk_i = 1'b0, rst_ni = 1'b0, us_tick_i = 1'b0;
  logic [2:0] mode_i = 3'd0;
  logic [1:0] pd_i = 2'b00;
  logic [N-1:0] det_result_i = '0;
  logic [N-1:0] probe_o, done_o, term_o;

  int checks = 0, errors = 0;
  int cyc = 0;
  int pcnt [N];
  int last [N];
  int gap [N];
  logic [15:0] pat [N];
  logic wide_pulse = 1'b0;
  logic [N-1:0] prev_probe = '0;

  rxdet_poll_ctrl #(.NUM_LANES(N), .POLL_US(POLL), .RETRY_US(RETRY), .PD_HOLD_US(HOLD)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .us_tick_i(us_tick_i), .mode_i(mode_i), .pd_i(pd_i),
    .det_result_i(det_result_i), .probe_o(probe_o), .done_o(done_o), .term_o(term_o)
  );

  always #4 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  initial begin
    forever begin
      repeat (TICK_DIV - 1) @(posedge clk_i);
      us_tick_i <= 1'b1;
      @(posedge clk_i);
      us_tick_i <= 1'b0;
    end
  end

  // far-end model: answer each probe from the lane's script, indexed by probe number
  always @(negedge clk_i) begin
    for (int l = 0; l < N; l++) begin
      if (probe_o[l]) begin
        if (prev_probe[l]) wide_pulse <= 1'b1;
        det_result_i[l] <= pat[l][(pcnt[l] > 15) ? 15 : pcnt[l]];
        gap[l]  <= cyc - last[l];
        last[l] <= cyc;
        pcnt[l] <= pcnt[l] + 1;
      end
    end
    prev_probe <= probe_o;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic start(input logic [2:0] m, input logic [15:0] dflt);
    @(negedge clk_i);
    rst_ni = 1'b0;
    pd_i   = 2'b00;
    mode_i = m;
    for (int l = 0; l < N; l++) begin
      pat[l] = dflt; pcnt[l] = 0; last[l] = 0; gap[l] = 0;
    end
    wait_cyc(3);
    chk("R11 done cleared in reset", int'(done_o), 0);
    chk("R11 no probe in reset", int'(probe_o), 0);
    rst_ni = 1'b1;
  endtask

  task automatic t_off();
    start(3'd0, 16'hFFFF);
    wait_cyc(800);
    chk("R1 off term", int'(term_o), 8'hFF);
    chk("R1 off done", int'(done_o), 0);
    chk("R1 off probes", pcnt[0] + pcnt[7], 0);
    start(3'd3, 16'hFFFF);
    wait_cyc(800);
    chk("R1 reserved term", int'(term_o), 8'hFF);
    chk("R1 reserved probes", pcnt[3], 0);
    start(3'd6, 16'hFFFF);
    wait_cyc(200);
    chk("R1 level6 term", int'(term_o), 8'hFF);
  endtask

  task automatic t_cnt3();
    start(3'd1, 16'hFFFF);
    pat[1] = 16'hFFFB;
    pat[2] = 16'h0000;
    wait_cyc(2);
    chk("R5 hiz before detect", int'(term_o), 0);
    wait_cyc(320);
    chk("R2 done mask", int'(done_o), 8'hFB);
    chk("R5 term mask", int'(term_o), 8'hFB);
    chk("R2 three probes", pcnt[0], 3);
    chk("R4 run restarts after bad verdict", pcnt[1], 6);
    chk("R7 retry spacing", gap[2], RETRY * TICK_DIV);
    wait_cyc(100);
    chk("R2 no probe after done", pcnt[0], 3);
  endtask

  task automatic t_cnt2();
    start(3'd2, 16'hFFFF);
    pat[3] = 16'hFFFD;
    wait_cyc(250);
    chk("R3 done all", int'(done_o), 8'hFF);
    chk("R3 two probes", pcnt[0], 2);
    chk("R4 two-count restart", pcnt[3], 4);
  endtask

  task automatic t_periodic();
    start(3'd4, 16'hFFFF);
    pat[0] = 16'hFFFC;
    pat[5] = 16'h0000;
    wait_cyc(POLL * TICK_DIV * 2 + 100);
    chk("R5 pending lane hiz", int'(term_o[0]), 0);
    chk("R6 two probes so far", pcnt[0], 2);
    wait_cyc(POLL * TICK_DIV);
    chk("R6 done mask", int'(done_o), 8'hDF);
    chk("R6 lane0 probes", pcnt[0], 3);
    chk("R6 single probe on good lane", pcnt[1], 1);
    chk("R6 poll spacing", gap[5], POLL * TICK_DIV);
  endtask

  task automatic t_pd_cnt();
    start(3'd1, 16'hFFFF);
    wait_cyc(200);
    chk("R9 initial done", int'(done_o), 8'hFF);
    pd_i = 2'b01;
    wait_cyc(150);
    chk("R9 lower half hiz", int'(term_o), 8'hF0);
    chk("R9 lower half done cleared", int'(done_o), 8'hF0);
    chk("R9 no probe while held", pcnt[0], 3);
    pd_i = 2'b00;
    wait_cyc(200);
    chk("R9 redetect done", int'(done_o), 8'hFF);
    chk("R9 lower half reprobed", pcnt[0], 6);
    chk("R9 upper half untouched", pcnt[4], 3);
  endtask

  task automatic t_pd_per();
    start(3'd4, 16'hFFFF);
    wait_cyc(POLL * TICK_DIV + 100);
    chk("R6 all done", int'(done_o), 8'hFF);
    pd_i = 2'b11;
    wait_cyc(50 * TICK_DIV);
    chk("R10 short pulse hiz", int'(term_o), 0);
    pd_i = 2'b00;
    wait_cyc(10);
    chk("R10 short pulse keeps done", int'(done_o), 8'hFF);
    chk("R10 short pulse term back", int'(term_o), 8'hFF);
    wait_cyc(POLL * TICK_DIV + 100);
    chk("R10 no reprobe", pcnt[0], 1);
    pd_i = 2'b11;
    wait_cyc((HOLD + 20) * TICK_DIV);
    pd_i = 2'b00;
    wait_cyc(10);
    chk("R10 long pulse clears", int'(done_o), 0);
    chk("R10 long pulse term hiz", int'(term_o), 0);
    wait_cyc(POLL * TICK_DIV + 100);
    chk("R10 redetect", int'(done_o), 8'hFF);
    chk("R10 one fresh probe", pcnt[0], 2);
  endtask

  initial begin
    fork
      begin
        t_off();
        t_cnt3();
        t_cnt2();
        t_periodic();
        t_pd_cnt();
        t_pd_per();
        chk("R8 probe pulse width", int'(wide_pulse), 0);
      end
      begin
        repeat (200000) @(posedge clk_i);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule